// File: doc/BRIEF.md
# Synchronous FIFO with Rewindable Read Pointer

This block is a single-clock first-in first-out buffer with full and empty flags. It can also replay a packet on request. An active-low retransmit input sends the read pointer back to the first physical storage location. Every word written since the last master reset can then be read out again, in its original order. Words written after the rewind follow those words in the read stream. The rewind may be repeated as often as needed over the same stored data.

The flags are not held as separate state. They are derived from the distance between the write and read pointers, so a rewind updates them in the same cycle as the pointer. After an accepted retransmit request, the read side is locked out. The lockout lasts while the request input stays low and for a parameterised number of recovery cycles after it returns high. A read attempted in that window is discarded and reported as a protocol error.

A rewind is only meaningful while the storage has not wrapped. For that reason the block counts accepted writes since reset. It refuses a retransmit request once that count has reached DEPTH minus 2, and raises a separate error pulse. DEPTH must be a power of two.

Top module: `rtx_fifo`

## Requirements
- R1: A retransmit request is a cycle with `rtxN` low after a cycle with it high (or after reset). If it is accepted, the read pointer becomes 0 at that clock edge, and the next accepted read returns the first word written since reset.
- R2: After an accepted request, a read is ignored in these cycles: the request cycle, every following cycle while `rtxN` stays low, and the RECOVER_CYC cycles after `rtxN` is first sampled high. An ignored read leaves `rdData` and the read pointer unchanged.
- R3: `rdLockErr` is high for exactly the one cycle after any cycle in which `rdEn` was high inside the R2 lockout window. It is low otherwise.
- R4: `full` is high exactly when write pointer minus read pointer equals DEPTH. `empty` is high exactly when that difference is 0. After an accepted request, the difference equals the number of words written since reset.
- R5: After a rewind, successive reads return the stored words in write order. They continue into words written after the rewind, until the FIFO is empty.
- R6: A request made when the count of accepted writes since reset is at least DEPTH-2 is rejected. In that case `rtxLimitErr` is high for the following cycle, and the read pointer, the data and the read lockout are unaffected: a read in the request cycle is accepted.
- R7: Retransmit may be issued again after a previous rewind, and it replays from location 0 again.
- R8: A write while `full` is ignored. A read while `empty` is ignored, and `rdData` keeps its previous value.
- R9: `rdData` is registered. It takes the word at the read pointer on the clock edge that accepts a read, and holds it otherwise.
- R10: While `rstN` is low: `empty` is 1; `full`, `rdData`, `rdLockErr` and `rtxLimitErr` are 0; and the write count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Registered read word |
| rtxN | input | 1 | Active-low retransmit request |
| full | output | 1 | Storage holds DEPTH words |
| empty | output | 1 | Storage holds no unread words |
| rdLockErr | output | 1 | Read attempted during retransmit lockout (one-cycle pulse) |
| rtxLimitErr | output | 1 | Retransmit refused because too many words were written (one-cycle pulse) |

## Verification
A read pointer that is not rewound, or is rewound to the wrong place, shows up on the first read after the recovery window. At that point `rdData` returns a word other than the first one written since reset, and `empty` reports the wrong occupancy right after the request edge. A lockout counter that runs too long or too short shows up as a missing or spurious `rdLockErr` one cycle after a read attempt. It also shows up as a read that is consumed, or refused, when it should not be, and that is visible in `rdData` the next cycle. A wrong write count shows up as a wrong `rtxLimitErr` decision on the request at the DEPTH-2 boundary.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  // Strobes from the pointer control into the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/rtx_fifo_seq.sv
module rtx_fifo_seq #(
  parameter int RECOVER_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rtxN,
  input  logic rdEn,
  input  logic atLimit,
  output logic rewind,
  output logic rdLocked,
  output logic rdLockErr,
  output logic rtxLimitErr
);
  localparam int LOCK_W = $clog2(RECOVER_CYC + 1);

  logic              rtxPrev;
  logic              inRtx;
  logic [LOCK_W-1:0] lockCnt;
  logic              request;
  logic              accept;
  logic              holding;

  // A request is the first low sample of rtxN after a high sample.
  assign request  = ~rtxN & rtxPrev;
  assign accept   = request & ~atLimit;
  assign holding  = ~rtxN & (accept | inRtx);
  assign rdLocked = holding | (lockCnt != '0);
  assign rewind   = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtxPrev     <= 1'b1;
      inRtx       <= 1'b0;
      lockCnt     <= '0;
      rdLockErr   <= 1'b0;
      rtxLimitErr <= 1'b0;
    end else begin
      rtxPrev <= rtxN;
      if (holding) begin
        lockCnt <= LOCK_W'(RECOVER_CYC);
      end else if (lockCnt != '0) begin
        lockCnt <= lockCnt - 1'b1;
      end
      if (accept) begin
        inRtx <= 1'b1;
      end else if (rtxN) begin
        inRtx <= 1'b0;
      end
      rdLockErr   <= rdEn & rdLocked;
      rtxLimitErr <= request & atLimit;
    end
  end
endmodule

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic                       rdLocked,
  input  logic                       rewind,
  output fifoStrobe_t                strobe,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [$clog2(DEPTH):0]     wrPtr,
  output logic [$clog2(DEPTH):0]     rdPtr,
  output logic                       full,
  output logic                       empty,
  output logic                       atLimit
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LIMIT  = DEPTH - 2;

  logic [PTR_W-1:0] occupancy;
  logic [CNT_W-1:0] wrCount;

  assign occupancy = wrPtr - rdPtr;
  assign full      = (occupancy == PTR_W'(DEPTH));
  assign empty     = (occupancy == '0);
  assign atLimit   = (wrCount >= CNT_W'(LIMIT));

  assign strobe.push = wrEn & ~full;
  assign strobe.pop  = rdEn & ~empty & ~rdLocked;
  assign wrAddr      = wrPtr[ADDR_W-1:0];
  assign rdAddr      = rdPtr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wrCount <= '0;
    end else begin
      if (strobe.push) begin
        wrPtr <= wrPtr + 1'b1;
        if (!atLimit) wrCount <= wrCount + 1'b1;
      end
      if (rewind) begin
        rdPtr <= '0;
      end else if (strobe.pop) begin
        rdPtr <= rdPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtx_fifo_dp.sv
module rtx_fifo_dp
  import rtx_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fifoStrobe_t              strobe,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.pop) begin
      rdData <= store[rdAddr];
    end
  end
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int RECOVER_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              rtxN,
  output logic              full,
  output logic              empty,
  output logic              rdLockErr,
  output logic              rtxLimitErr
);
  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W:0]   wrPtr;
  logic [ADDR_W:0]   rdPtr;
  logic              rewind;
  logic              rdLocked;
  logic              atLimit;

  rtx_fifo_seq #(.RECOVER_CYC(RECOVER_CYC)) seqInst (
    .clk(clk), .rstN(rstN), .rtxN(rtxN), .rdEn(rdEn), .atLimit(atLimit),
    .rewind(rewind), .rdLocked(rdLocked), .rdLockErr(rdLockErr),
    .rtxLimitErr(rtxLimitErr)
  );

  rtx_fifo_ctrl #(.DEPTH(DEPTH)) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdLocked(rdLocked),
    .rewind(rewind), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty), .atLimit(atLimit)
  );

  rtx_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             rtxN,
  input logic             full,
  input logic             empty,
  input logic             rdLockErr,
  input logic             rtxLimitErr,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrPtr));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && rtxN) |=> $stable(rdPtr));

  assert_lock_err_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdLockErr |-> $past(rdEn));

  assert_rewind_or_refuse_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtxN) |=> (rdPtr == '0 || rtxLimitErr));

  assert_refuse_needs_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    rtxLimitErr |-> $past(!rtxN));
endmodule

bind rtx_fifo rtx_fifo_chk #(.PTR_W($clog2(DEPTH) + 1)) chkInst (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rtxN(rtxN),
  .full(full), .empty(empty), .rdLockErr(rdLockErr), .rtxLimitErr(rtxLimitErr),
  .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/rtx_fifo_test.sv
`timescale 1ns/1ps
module rtx_fifo_test;
  localparam int DW = 8;
  localparam int D  = 16;
  localparam int RC = 2;
  localparam int LIMIT = D - 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rtxN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic full, empty, rdLockErr, rtxLimitErr;

  rtx_fifo #(.DATA_W(DW), .DEPTH(D), .RECOVER_CYC(RC)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rtxN(rtxN), .full(full), .empty(empty),
    .rdLockErr(rdLockErr), .rtxLimitErr(rtxLimitErr)
  );

  int vectors = 0, fails = 0;

  // Reference model state
  logic [DW-1:0] mMem [D];
  int mWr, mRd, mCnt, mLock;
  bit mInRtx, mPrev, mLockErr, mLimErr;
  logic [DW-1:0] mData;

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mWr = 0; mRd = 0; mCnt = 0; mLock = 0;
    mInRtx = 0; mPrev = 1; mLockErr = 0; mLimErr = 0; mData = '0;
  endfunction

  function automatic void modelStep(bit w, logic [DW-1:0] d, bit r, bit x);
    int occ = mWr - mRd;
    bit fullM = (occ == D);
    bit emptyM = (occ == 0);
    bit req = !x && mPrev;
    bit acc = req && (mCnt < LIMIT);
    bit hold = !x && (acc || mInRtx);
    bit locked = hold || (mLock != 0);
    bit push = w && !fullM;
    bit pop = r && !emptyM && !locked;
    mLockErr = r && locked;
    mLimErr = req && !acc;
    if (push) begin
      mMem[mWr % D] = d;
      mWr++;
      if (mCnt < LIMIT) mCnt++;
    end
    if (pop) begin
      mData = mMem[mRd % D];
      mRd++;
    end
    if (acc) mRd = 0;
    if (hold) mLock = RC;
    else if (mLock != 0) mLock--;
    if (acc) mInRtx = 1;
    else if (x) mInRtx = 0;
    mPrev = x;
  endfunction

  task automatic checkAll();
    chk("R4", "full", full, ((mWr - mRd) == D));
    chk("R4", "empty", empty, ((mWr - mRd) == 0));
    chk("R9", "rdData", rdData, mData);
    chk("R3", "rdLockErr", rdLockErr, mLockErr);
    chk("R6", "rtxLimitErr", rtxLimitErr, mLimErr);
  endtask

  task automatic step(bit w, logic [DW-1:0] d, bit r, bit x);
    wrEn = w; wrData = d; rdEn = r; rtxN = x;
    @(posedge clk);
    modelStep(w, d, r, x);
    @(negedge clk);
    checkAll();
  endtask

  task automatic masterReset();
    rstN = 1'b0; wrEn = 0; rdEn = 0; rtxN = 1;
    @(negedge clk); @(negedge clk);
    chk("R10", "empty in reset", empty, 1);
    chk("R10", "full in reset", full, 0);
    chk("R10", "rdData in reset", rdData, 0);
    chk("R10", "errors in reset", {rdLockErr, rtxLimitErr}, 0);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    masterReset();

    // Fill to full, overflow attempt, drain, underflow attempt
    for (int i = 0; i < D; i++) step(1, DW'(i * 3 + 1), 0, 1);
    chk("R4", "full after DEPTH writes", full, 1);
    step(1, 8'hEE, 0, 1);
    chk("R8", "write while full ignored", full, 1);
    for (int i = 0; i < D; i++) begin
      step(0, 0, 1, 1);
      chk("R9", "drain order", rdData, DW'(i * 3 + 1));
    end
    step(0, 0, 1, 1);
    chk("R8", "read while empty holds data", rdData, DW'((D - 1) * 3 + 1));

    // Retransmit scenario
    masterReset();
    for (int i = 0; i < 5; i++) step(1, DW'(8'hA0 + i), 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1);
    chk("R9", "third read", rdData, 8'hA2);
    step(0, 0, 1, 0);
    chk("R4", "occupancy after rewind", empty, 0);
    step(1, 8'hB0, 1, 0);
    chk("R3", "read during pulse flagged", rdLockErr, 1);
    step(0, 0, 1, 1);
    chk("R2", "read in recovery ignored", rdData, 8'hA2);
    step(0, 0, 1, 1);
    chk("R2", "read in recovery ignored 2", rdData, 8'hA2);
    chk("R3", "recovery read flagged", rdLockErr, 1);
    step(0, 0, 1, 1);
    chk("R1", "first word replayed", rdData, 8'hA0);
    chk("R3", "no error after recovery", rdLockErr, 0);
    step(1, 8'hB1, 1, 1);
    chk("R5", "second word replayed", rdData, 8'hA1);
    for (int i = 2; i < 5; i++) begin
      step(0, 0, 1, 1);
      chk("R5", "replay order", rdData, DW'(8'hA0 + i));
    end
    step(0, 0, 1, 1);
    chk("R5", "post-rewind write delivered", rdData, 8'hB0);
    step(0, 0, 1, 1);
    chk("R5", "second post-rewind write", rdData, 8'hB1);
    chk("R4", "empty after replay", empty, 1);

    // Repeat retransmit
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    chk("R7", "second rewind replays first word", rdData, 8'hA0);

    // Limit: DEPTH-2 writes then refused request
    masterReset();
    for (int i = 0; i < LIMIT; i++) step(1, DW'(8'h40 + i), 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 0);
    chk("R6", "refused request flagged", rtxLimitErr, 1);
    chk("R6", "read in refused request cycle taken", rdData, 8'h42);
    chk("R3", "no lockout on refusal", rdLockErr, 0);
    step(0, 0, 1, 1);
    chk("R6", "pointer not rewound", rdData, 8'h43);

    // Random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit w = ($urandom_range(0, 99) < 55);
      bit r = ($urandom_range(0, 99) < 50);
      bit x = ($urandom_range(0, 99) >= 4);
      if (cyc % 1000 == 999) masterReset();
      else step(w, DW'($urandom), r, x);
    end

    finishRun();
  end
endmodule